// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a 48-bit physical address. It walks a four-level tree of 8-byte descriptors with a 4 KB granule. A request arrives on a valid/ready handshake. The walker first checks that the upper address bits form a legal pattern, then picks one of two table base inputs using the top address bit.

After that it issues one memory read per level on a simple request/response port. Each read address is built from the current table base and a 9-bit slice of the virtual address. The walk stops when it reaches a leaf (a 1 GB or 2 MB block, or a 4 KB page) or when it meets an illegal descriptor.

The result is a one-cycle pulse that carries:
- the physical address,
- the level at which the walk ended,
- a fault flag,
- a fault cause.

Only one walk is in flight at a time. The walker accepts nothing new until it has delivered the result of the current walk.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. It drops on the cycle after a request is accepted and returns high on the cycle after the result pulse. Out of reset it is high, and `res_valid` and `mem_req_valid` are low.
- R2: A request with `req_va[63:48]` neither all zeros nor all ones gives a fault result on the cycle right after acceptance. That result has `res_cause` = 1 (address size) and `res_level` = 0, and no memory read is issued for it.
- R3: `req_va[63]` = 0 selects `base_lo` and 1 selects `base_hi`. The level-0 read address is `{base[47:12], req_va[47:39], 3'b000}`, so base bits [11:0] are ignored.
- R4: The read at level n (n = 0..3) uses address `{table[47:12], idx_n, 3'b000}`, where idx_n is `req_va[47-9n : 39-9n]`. A table descriptor's next table base is its bits [47:12]; its bits [63:48] and [11:2] are ignored.
- R5: A descriptor with bit 0 = 0 at any level ends the walk with a fault, `res_cause` = 2 (translation), and `res_level` equal to that level.
- R6: Descriptor type `2'b01` (block) at level 0 or at level 3 ends the walk with a translation fault at that level.
- R7: Type `2'b01` at level 1 gives `res_pa = {desc[47:30], va[29:0]}`. At level 2 it gives `res_pa = {desc[47:21], va[20:0]}`. In both cases `res_level` is that level and there is no fault.
- R8: Type `2'b11` at level 3 gives `res_pa = {desc[47:12], va[11:0]}` with `res_level` = 3 and no fault. At levels 0 to 2, type `2'b11` is followed as a table pointer.
- R9: A walk ending at level L issues exactly L+1 reads. Each read is a one-cycle `mem_req_valid` pulse, and there is never more than one outstanding read.
- R10: `res_valid` is a one-cycle pulse. On a fault `res_pa` is 0. On success `res_fault` is 0 and `res_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_va | input | 64 | Virtual address to translate |
| base_lo | input | 48 | Root table base for the lower (bit 63 = 0) range |
| base_hi | input | 48 | Root table base for the upper (bit 63 = 1) range |
| mem_req_valid | output | 1 | One-cycle descriptor read request |
| mem_req_addr | output | 48 | Byte address of the descriptor to read |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 64 | Descriptor value |
| res_valid | output | 1 | One-cycle result pulse |
| res_pa | output | 48 | Translated physical address (0 on fault) |
| res_level | output | 2 | Level where the walk ended or faulted |
| res_fault | output | 1 | Walk ended in a fault |
| res_cause | output | 2 | 0 none, 1 address size, 2 translation |

## Verification
The bench sweeps every level against every descriptor type code, for addresses in both the lower and the upper range. It also flips each of the sixteen upper bits, one at a time, in both ranges. For each walk it checks the exact sequence of read addresses, which catches several kinds of error:
- a wrong index slice, or a base taken from the wrong register, lands on an empty entry, which shows up as a spurious fault;
- a walker that accepts a level-0 block, or follows a pointer from level 3, returns a success where a fault is due;
- a walker that leaks descriptor attribute bits, or low base bits, produces a corrupted read address or physical address;
- a non-canonical address that is not rejected at once shows up as a read on the memory port or as a late result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W            = 64;
    localparam int VA_BITS         = 48;
    localparam int OA_W            = 48;
    localparam int DESC_W          = 64;
    localparam int PAGE_SHIFT      = 12;
    localparam int IDX_W           = 9;
    localparam int NUM_LVL         = 4;
    localparam int LVL_W           = $clog2(NUM_LVL);
    localparam int ENTRY_LOG2      = 3;
    localparam int MIN_BLOCK_LVL   = 1;
    localparam int LAST_LVL        = NUM_LVL - 1;

    typedef logic [VA_W-1:0]   va_t;
    typedef logic [OA_W-1:0]   oa_t;
    typedef logic [DESC_W-1:0] desc_t;
    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [1:0] {
        CAUSE_NONE      = 2'd0,
        CAUSE_ADDR_SIZE = 2'd1,
        CAUSE_XLATE     = 2'd2
    } cause_e;

    typedef enum logic [1:0] {
        DEC_FAULT = 2'd0,
        DEC_LEAF  = 2'd1,
        DEC_NEXT  = 2'd2
    } dec_kind_e;

    typedef struct packed {
        dec_kind_e kind;
        oa_t       addr;
    } dec_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } st_e;

    // Bit position of the lowest VA bit that indexes the table at a level.
    function automatic int unsigned lvl_shift(input int unsigned lvl);
        return PAGE_SHIFT + IDX_W * (NUM_LVL - 1 - lvl);
    endfunction

    function automatic idx_t va_index(input va_t va, input lvl_t lvl);
        va_t s;
        s = va >> lvl_shift(int'(lvl));
        return s[IDX_W-1:0];
    endfunction

    function automatic oa_t entry_addr(input oa_t tbl, input idx_t idx);
        oa_t a;
        a = {tbl[OA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
        a = a | (oa_t'(idx) << ENTRY_LOG2);
        return a;
    endfunction

endpackage

// File: rtl/ptw_va_front.sv
module ptw_va_front
    import ptw_pkg::*;
(
    input  va_t  va,
    input  oa_t  base_lo,
    input  oa_t  base_hi,
    output logic canonical,
    output oa_t  root_tbl
);
    localparam int TOP_W = VA_W - VA_BITS;

    logic [TOP_W-1:0] top_bits;

    always_comb begin
        top_bits  = va[VA_W-1:VA_BITS];
        canonical = (top_bits == '0) || (top_bits == '1);
        root_tbl  = va[VA_W-1] ? base_hi : base_lo;
    end
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
(
    input  desc_t desc,
    input  lvl_t  lvl,
    input  va_t   va,
    output dec_t  dec
);
    oa_t leaf_by_lvl [NUM_LVL];

    genvar g;
    generate
        for (g = 0; g < NUM_LVL; g++) begin : g_leaf
            localparam int  SH  = PAGE_SHIFT + IDX_W * (NUM_LVL - 1 - g);
            localparam oa_t LOW = oa_t'((64'd1 << SH) - 64'd1);
            assign leaf_by_lvl[g] = (desc[OA_W-1:0] & ~LOW) | (va[OA_W-1:0] & LOW);
        end
    endgenerate

    logic is_last;
    logic block_ok;

    always_comb begin
        is_last  = (lvl == lvl_t'(LAST_LVL));
        block_ok = (lvl >= lvl_t'(MIN_BLOCK_LVL)) && !is_last;
        dec.kind = DEC_FAULT;
        dec.addr = '0;
        if (desc[0]) begin
            if (desc[1]) begin
                if (is_last) begin
                    dec.kind = DEC_LEAF;
                    dec.addr = leaf_by_lvl[lvl];
                end else begin
                    dec.kind = DEC_NEXT;
                    dec.addr = {desc[OA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
                end
            end else if (block_ok) begin
                dec.kind = DEC_LEAF;
                dec.addr = leaf_by_lvl[lvl];
            end
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_va,
    input  logic [OA_W-1:0]     base_lo,
    input  logic [OA_W-1:0]     base_hi,
    output logic                mem_req_valid,
    output logic [OA_W-1:0]     mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [DESC_W-1:0]   mem_rsp_data,
    output logic                res_valid,
    output logic [OA_W-1:0]     res_pa,
    output logic [LVL_W-1:0]    res_level,
    output logic                res_fault,
    output logic [1:0]          res_cause
);
    st_e    st;
    va_t    va_q;
    oa_t    tbl_q;
    lvl_t   lvl_q;
    oa_t    pa_q;
    lvl_t   res_lvl_q;
    cause_e cause_q;

    logic   canonical;
    oa_t    root_tbl;
    dec_t   dec;

    ptw_va_front u_front (
        .va        (req_va),
        .base_lo   (base_lo),
        .base_hi   (base_hi),
        .canonical (canonical),
        .root_tbl  (root_tbl)
    );

    ptw_desc_decode u_dec (
        .desc (mem_rsp_data),
        .lvl  (lvl_q),
        .va   (va_q),
        .dec  (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            va_q      <= '0;
            tbl_q     <= '0;
            lvl_q     <= '0;
            pa_q      <= '0;
            res_lvl_q <= '0;
            cause_q   <= CAUSE_NONE;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q  <= req_va;
                        tbl_q <= root_tbl;
                        lvl_q <= '0;
                        if (!canonical) begin
                            cause_q   <= CAUSE_ADDR_SIZE;
                            pa_q      <= '0;
                            res_lvl_q <= '0;
                            st        <= ST_DONE;
                        end else begin
                            st <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: st <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        unique case (dec.kind)
                            DEC_NEXT: begin
                                tbl_q <= dec.addr;
                                lvl_q <= lvl_q + lvl_t'(1);
                                st    <= ST_ISSUE;
                            end
                            DEC_LEAF: begin
                                cause_q   <= CAUSE_NONE;
                                pa_q      <= dec.addr;
                                res_lvl_q <= lvl_q;
                                st        <= ST_DONE;
                            end
                            default: begin
                                cause_q   <= CAUSE_XLATE;
                                pa_q      <= '0;
                                res_lvl_q <= lvl_q;
                                st        <= ST_DONE;
                            end
                        endcase
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready     = (st == ST_IDLE);
        mem_req_valid = (st == ST_ISSUE);
        mem_req_addr  = entry_addr(tbl_q, va_index(va_q, lvl_q));
        res_valid     = (st == ST_DONE);
        res_pa        = pa_q;
        res_level     = res_lvl_q;
        res_cause     = cause_q;
        res_fault     = (cause_q != CAUSE_NONE);
    end

    // Reads issued in the current walk, kept for the checks below.
    logic [2:0] rd_cnt;
    always_ff @(posedge clk) begin
        if (rst)                         rd_cnt <= '0;
        else if (req_valid && req_ready) rd_cnt <= '0;
        else if (mem_req_valid)          rd_cnt <= rd_cnt + 3'd1;
    end

    assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_noncanon_fault_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !canonical) |=>
            (res_valid && res_fault && res_cause == CAUSE_ADDR_SIZE
             && res_level == '0 && !mem_req_valid));

    assert_read_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    assert_read_budget_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (rd_cnt < 3'(NUM_LVL)));

    assert_reads_match_level_R9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_fault) |-> (rd_cnt == 3'(res_level) + 3'd1));

    assert_leaf_not_l0_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_fault) |-> (res_level != '0));

    assert_result_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    assert_fault_pa_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_fault) |-> (res_pa == '0));
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] BASE_LO  = 48'h0000_8000_0000;
    localparam logic [47:0] BASE_HI  = 48'h0001_2340_0ABC;
    localparam logic [47:0] TBL_POOL = 48'h0000_4000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_va = '0;
    logic [47:0] base_lo = BASE_LO;
    logic [47:0] base_hi = BASE_HI;
    logic        mem_req_valid;
    logic [47:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        res_valid;
    logic [47:0] res_pa;
    logic [1:0]  res_level;
    logic        res_fault;
    logic [1:0]  res_cause;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .base_lo(base_lo), .base_hi(base_hi),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_pa(res_pa), .res_level(res_level),
        .res_fault(res_fault), .res_cause(res_cause)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] mem [logic [47:0]];
    logic [47:0] rd_log [8];
    int          rd_n = 0;
    logic [47:0] exp_addr [4];
    bit          done = 1'b0;

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Memory model: answers each read after 1..3 cycles.
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                logic [47:0] a;
                a = mem_req_addr;
                if (rd_n < 8) rd_log[rd_n] = a;
                rd_n++;
                repeat (1 + rd_n % 3) @(negedge clk);
                mem_rsp_data  = mem.exists(a) ? mem[a] : 64'h0;
                mem_rsp_valid = 1'b1;
            end
        end
    end

    task automatic build_chain(input logic [63:0] va, input int leaf_lvl,
                               input logic [63:0] leaf_d);
        logic [47:0] tbl;
        mem.delete();
        tbl = va[63] ? BASE_HI : BASE_LO;
        for (int l = 0; l <= leaf_lvl; l++) begin
            logic [47:0] a;
            logic [47:0] nxt;
            a = {tbl[47:12], 12'h0} + 48'((va >> (39 - 9 * l)) & 64'h1FF) * 48'd8;
            exp_addr[l] = a;
            if (l == leaf_lvl) begin
                mem[a] = leaf_d;
            end else begin
                nxt = TBL_POOL + (48'(l + 1) << 20);
                mem[a] = {16'hC3A5, nxt[47:12], 10'h2B5, 2'b11};
                tbl = nxt;
            end
        end
    endtask

    task automatic run_walk(input logic [63:0] va, input int nrd, input bit f_exp,
                            input logic [1:0] c_exp, input logic [1:0] l_exp,
                            input logic [47:0] pa_exp, input string rq);
        int cyc;
        @(negedge clk);
        chk("R1", "ready before request", 64'(req_ready), 64'd1);
        rd_n = 0;
        req_va = va;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1", "ready dropped after accept", 64'(req_ready), 64'd0);
        cyc = 0;
        while (!res_valid && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk(rq, "result arrived", 64'(res_valid), 64'd1);
        if (nrd == 0) chk("R2", "immediate fault latency", 64'(cyc), 64'd0);
        chk(rq, "fault flag", 64'(res_fault), 64'(f_exp));
        chk(rq, "cause", 64'(res_cause), 64'(c_exp));
        chk(rq, "level", 64'(res_level), 64'(l_exp));
        chk(f_exp ? "R10" : rq, "physical address", 64'(res_pa), 64'(pa_exp));
        chk("R9", "read count", 64'(rd_n), 64'(nrd));
        for (int i = 0; i < nrd && i < 4; i++)
            chk(i == 0 ? "R3" : "R4", "read address", 64'(rd_log[i]), 64'(exp_addr[i]));
        @(negedge clk);
        chk("R10", "result is one pulse", 64'(res_valid), 64'd0);
        chk("R1", "ready after result", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "reset ready", 64'(req_ready), 64'd1);
        chk("R1", "reset res_valid", 64'(res_valid), 64'd0);
        chk("R1", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);

        // Level x type code sweep, both address ranges.
        for (int lvl = 0; lvl < 4; lvl++) begin
            for (int kind = 0; kind < 4; kind++) begin
                for (int v = 0; v < 6; v++) begin
                    logic [63:0] va;
                    logic [63:0] d;
                    logic [47:0] pa;
                    bit          f;
                    string       rq;
                    if (kind == 3 && lvl < 3) continue;
                    va = {{16{v[0]}}, 16'($urandom), 32'($urandom)};
                    d  = {16'h7E91, 36'({$urandom, $urandom}), 10'h3C6, 2'(kind)};
                    f  = 1'b1;
                    pa = '0;
                    rq = "R5";
                    if (kind == 1) begin
                        rq = "R6";
                        if (lvl == 1) begin
                            f = 1'b0; pa = {d[47:30], va[29:0]}; rq = "R7";
                        end else if (lvl == 2) begin
                            f = 1'b0; pa = {d[47:21], va[20:0]}; rq = "R7";
                        end
                    end else if (kind == 3) begin
                        f = 1'b0; pa = {d[47:12], va[11:0]}; rq = "R8";
                    end
                    build_chain(va, lvl, d);
                    run_walk(va, lvl + 1, f, f ? 2'd2 : 2'd0, 2'(lvl), pa, rq);
                end
            end
        end

        // Non-canonical: flip each upper bit in each range.
        for (int hi = 0; hi < 2; hi++) begin
            for (int b = 0; b < 16; b++) begin
                logic [63:0] va;
                va = {{16{hi[0]}}, 16'($urandom), 32'($urandom)};
                va[48 + b] = ~va[48 + b];
                mem.delete();
                run_walk(va, 0, 1'b1, 2'd1, 2'd0, 48'h0, "R2");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule